// File: doc/BRIEF.md
# Two-Operand Sum Register Slave

This block is a small memory-mapped peripheral on an AXI4-Lite slave port. Software writes two 32-bit operand registers. A third register, which software can only read, returns their sum as computed by the hardware. The address map is sparse. The operands sit at byte offsets 0x0 and 0x4. Offset 0x8 is an unused hole. The sum sits at offset 0xC.

The write side accepts the address and the data channels independently. They may arrive in either order or together. The register update happens only once both halves of the write are held. Byte strobes select which bytes of an operand change. Each channel allows one transaction in flight. A response is presented until the master takes it. All responses are OKAY, including writes to the hole or to the read-only sum, which leave the operands untouched.

Top module: `axil_sum_regs`

## Requirements
- R1: After the active-low synchronous reset, both operands read as zero, AWREADY, WREADY and ARREADY are 1, and BVALID and RVALID are 0.
- R2: A write to byte offset 0x0 (word index 0) sets the first operand, and a read of 0x0 returns it.
- R3: A write to byte offset 0x4 (word index 1) sets the second operand, and a read of 0x4 returns it.
- R4: A read of byte offset 0xC (word index 3) returns (first operand + second operand) mod 2^32, using the operand values at the edge on which the read address is accepted.
- R5: Writes to offsets 0x8 and 0xC leave both operands unchanged and still complete with BRESP = 2'b00. A read of 0x8 returns zero.
- R6: WSTRB bit i enables the update of byte lane i (bits 8i+7..8i) of the addressed operand. Lanes with a 0 strobe keep their old value.
- R7: The write address and write data may be accepted in either order or on the same edge. The register changes, and BVALID rises, one edge after the later of the two is accepted. While a half is held, its READY is 0.
- R8: Once BVALID is 1, it stays 1 with BRESP = 2'b00 until BREADY is seen. While it is 1, AWREADY and WREADY stay 0.
- R9: Once RVALID is 1, it stays 1 with RDATA stable and RRESP = 2'b00 until RREADY is seen. While it is 1, ARREADY is 0.
- R10: A read address accepted on the same edge as a write commit returns the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W (4) | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W (32) | Write data |
| s_wstrb | input | DATA_W/8 (4) | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W (4) | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W (32) | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
A write commit to an operand and the capture of a read address can fall on the same clock edge. The bench provokes this deliberately. It presents address and data together so the commit edge is known, then raises ARVALID for offset 0x0 in the cycle just before that edge. The returned word must be the operand's old value. A follow-up read must then show the new value, and BVALID must be up at the same sample point.

// File: rtl/axil_sum_pkg.sv
// Package: shared constants and register index names for the sum peripheral.
// Assumes a 32-bit-aligned register map (word index = byte address >> 2).
package axil_sum_pkg;
    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Word indices of the register map; index 2 is a hole.
    localparam int IDX_OPA  = 0;
    localparam int IDX_OPB  = 1;
    localparam int IDX_HOLE = 2;
    localparam int IDX_SUM  = 3;
endpackage

// File: rtl/sum_regfile.sv
// Module: operand storage with per-byte write enables and a combinational adder.
// Holds two operands, returns the read word for a given word index, and drives
// zero for the hole and for any index outside the map. Assumes DATA_W % 8 == 0.
module sum_regfile
    import axil_sum_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W/8-1:0] wr_strb,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] sum
);
    localparam int NLANE = DATA_W / 8;

    logic sel_a, sel_b;

    // Purpose: decode which operand, if any, the committed write targets.
    always_comb begin
        sel_a = wr_en && (wr_idx == IDX_W'(IDX_OPA));
        sel_b = wr_en && (wr_idx == IDX_W'(IDX_OPB));
    end

    for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
        // Purpose: update one byte lane of each operand under its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op_a[ln*8 +: 8] <= '0;
                op_b[ln*8 +: 8] <= '0;
            end else begin
                if (sel_a && wr_strb[ln]) op_a[ln*8 +: 8] <= wr_data[ln*8 +: 8];
                if (sel_b && wr_strb[ln]) op_b[ln*8 +: 8] <= wr_data[ln*8 +: 8];
            end
        end
    end

    // Purpose: modulo-2^DATA_W sum of the stored operands.
    always_comb sum = op_a + op_b;

    // Purpose: read multiplexer over the sparse map.
    always_comb begin
        if (rd_idx == IDX_W'(IDX_OPA))      rd_data = op_a;
        else if (rd_idx == IDX_W'(IDX_OPB)) rd_data = op_b;
        else if (rd_idx == IDX_W'(IDX_SUM)) rd_data = sum;
        else                                rd_data = '0;
    end
endmodule

// File: rtl/axil_wr_path.sv
// Module: write side of the slave. It captures the address and data halves independently,
// issues a one-cycle commit once both are held, and then holds the response until accepted.
// Assumes one outstanding write: no half is accepted while a response is pending.
module axil_wr_path
    import axil_sum_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    aw_idx,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W/8-1:0] wr_strb
);
    logic aw_held, w_held;

    // Purpose: channel readiness; a held half or a pending response blocks acceptance.
    always_comb begin
        awready = !aw_held && !bvalid;
        wready  = !w_held && !bvalid;
        wr_en   = aw_held && w_held;
        bresp   = RESP_OKAY;
    end

    // Purpose: capture halves, commit, and manage the response handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            wr_strb <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_held <= 1'b1;
                wr_idx  <= aw_idx;
            end
            if (wvalid && wready) begin
                w_held  <= 1'b1;
                wr_data <= wdata;
                wr_strb <= wstrb;
            end
            if (wr_en) begin
                aw_held <= 1'b0;
                w_held  <= 1'b0;
                bvalid  <= 1'b1;
            end else if (bvalid && bready) begin
                bvalid  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/axil_rd_path.sv
// Module: read side of the slave. It samples the register word when the address is
// accepted and holds the data until the master takes it. One read in flight.
module axil_rd_path
    import axil_sum_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready
);
    // Purpose: address acceptance blocked while a read response is pending.
    always_comb begin
        arready = !rvalid;
        rresp   = RESP_OKAY;
    end

    // Purpose: latch read data on acceptance and release on the data handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= word_in;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/axil_sum_regs.sv
// Module: top of the sum peripheral. It joins the write path, read path and register file.
// Byte addresses are converted to word indices; the two low address bits are ignored.
module axil_sum_regs
    import axil_sum_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                aclk,
    input  logic                aresetn,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready
);
    localparam int IDX_W = ADDR_W - 2;

    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx;
    logic [DATA_W-1:0]   wr_data;
    logic [DATA_W/8-1:0] wr_strb;
    logic [DATA_W-1:0]   rd_word;
    logic [DATA_W-1:0]   op_a, op_b, sum_val;
    logic                unused_lo;

    assign unused_lo = ^{s_awaddr[1:0], s_araddr[1:0], sum_val};

    axil_wr_path #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wr (
        .clk(aclk), .rst_n(aresetn),
        .aw_idx(s_awaddr[ADDR_W-1:2]), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
    );

    sum_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk(aclk), .rst_n(aresetn),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_idx(s_araddr[ADDR_W-1:2]), .rd_data(rd_word),
        .op_a(op_a), .op_b(op_b), .sum(sum_val)
    );

    axil_rd_path #(.DATA_W(DATA_W)) u_rd (
        .clk(aclk), .rst_n(aresetn),
        .arvalid(s_arvalid), .arready(s_arready), .word_in(rd_word),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready)
    );
endmodule

// File: rtl/axil_sum_regs_chk.sv
// Module: protocol and function checker bound to axil_sum_regs.
// It observes only. It assumes the index encoding given in axil_sum_pkg.
module axil_sum_regs_chk
    import axil_sum_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              aclk,
    input logic              aresetn,
    input logic [ADDR_W-1:0] s_araddr,
    input logic              s_arvalid,
    input logic              s_arready,
    input logic              s_awready,
    input logic              s_wready,
    input logic [1:0]        s_bresp,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [DATA_W-1:0] s_rdata,
    input logic [1:0]        s_rresp,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic              wr_en,
    input logic [ADDR_W-3:0] wr_idx,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b
);
    p_bvalid_hold_r8: assert property (@(posedge aclk) disable iff (!aresetn)
        s_bvalid && !s_bready |=> s_bvalid);
    p_bresp_okay_r8: assert property (@(posedge aclk) disable iff (!aresetn)
        s_bvalid |-> s_bresp == RESP_OKAY);
    p_wr_blocked_r8: assert property (@(posedge aclk) disable iff (!aresetn)
        s_bvalid |-> !s_awready && !s_wready);
    p_rvalid_hold_r9: assert property (@(posedge aclk) disable iff (!aresetn)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
    p_rresp_okay_r9: assert property (@(posedge aclk) disable iff (!aresetn)
        s_rvalid |-> s_rresp == RESP_OKAY && !s_arready);
    p_commit_blocks_r7: assert property (@(posedge aclk) disable iff (!aresetn)
        wr_en |-> !s_awready && !s_wready);
    p_commit_resp_r7: assert property (@(posedge aclk) disable iff (!aresetn)
        wr_en |=> s_bvalid);
    p_ignored_write_r5: assert property (@(posedge aclk) disable iff (!aresetn)
        wr_en && (wr_idx == (ADDR_W-2)'(IDX_HOLE) || wr_idx == (ADDR_W-2)'(IDX_SUM))
        |=> $stable(op_a) && $stable(op_b));
    p_sum_read_r4: assert property (@(posedge aclk) disable iff (!aresetn)
        s_arvalid && s_arready && s_araddr[ADDR_W-1:2] == (ADDR_W-2)'(IDX_SUM)
        |=> s_rdata == $past(op_a + op_b));
endmodule

bind axil_sum_regs axil_sum_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .aclk(aclk), .aresetn(aresetn), .s_araddr(s_araddr), .s_arvalid(s_arvalid),
    .s_arready(s_arready), .s_awready(s_awready), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_en(wr_en), .wr_idx(wr_idx), .op_a(op_a), .op_b(op_b)
);

// File: tb/axil_sum_regs_test.sv
// Bench: a vector table walked by one loop, then directed reset, hold and collision tests.
module axil_sum_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    axil_sum_regs uut (
        .aclk(clk), .aresetn(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    // Vector layout: [79:76] req, [75:74] op (0 write, 1 read), [73:72] order
    // (0 together, 1 address first, 2 data first), [71:68] addr, [67:64] strb,
    // [63:32] data, [31:0] expected read data.
    localparam int NV = 21;
    localparam logic [79:0] VEC [0:NV-1] = '{
        {4'd2,  2'd0, 2'd0, 4'h0, 4'hF, 32'h0000_0005, 32'h0},           // R2
        {4'd3,  2'd0, 2'd1, 4'h4, 4'hF, 32'h0000_0007, 32'h0},           // R3 address first
        {4'd4,  2'd1, 2'd0, 4'hC, 4'h0, 32'h0,         32'h0000_000C},   // R4
        {4'd2,  2'd1, 2'd0, 4'h0, 4'h0, 32'h0,         32'h0000_0005},   // R2
        {4'd3,  2'd1, 2'd0, 4'h4, 4'h0, 32'h0,         32'h0000_0007},   // R3
        {4'd6,  2'd0, 2'd2, 4'h0, 4'h3, 32'hAAAA_1234, 32'h0},           // R6 data first
        {4'd6,  2'd1, 2'd0, 4'h0, 4'h0, 32'h0,         32'h0000_1234},   // R6
        {4'd6,  2'd0, 2'd0, 4'h4, 4'hC, 32'hFFFF_0000, 32'h0},           // R6 upper lanes
        {4'd6,  2'd1, 2'd0, 4'h4, 4'h0, 32'h0,         32'hFFFF_0007},   // R6
        {4'd4,  2'd1, 2'd0, 4'hC, 4'h0, 32'h0,         32'hFFFF_123B},   // R4
        {4'd7,  2'd0, 2'd1, 4'h0, 4'hF, 32'hFFFF_FFFF, 32'h0},           // R7
        {4'd7,  2'd0, 2'd2, 4'h4, 4'hF, 32'h0000_0001, 32'h0},           // R7
        {4'd4,  2'd1, 2'd0, 4'hC, 4'h0, 32'h0,         32'h0000_0000},   // R4 wrap
        {4'd5,  2'd0, 2'd0, 4'hC, 4'hF, 32'h1234_5678, 32'h0},           // R5 write sum
        {4'd5,  2'd0, 2'd1, 4'h8, 4'hF, 32'h0000_DEAD, 32'h0},           // R5 write hole
        {4'd5,  2'd1, 2'd0, 4'h0, 4'h0, 32'h0,         32'hFFFF_FFFF},   // R5
        {4'd5,  2'd1, 2'd0, 4'h4, 4'h0, 32'h0,         32'h0000_0001},   // R5
        {4'd5,  2'd1, 2'd0, 4'h8, 4'h0, 32'h0,         32'h0000_0000},   // R5 hole reads 0
        {4'd6,  2'd0, 2'd0, 4'h0, 4'h0, 32'h0000_0000, 32'h0},           // R6 no strobes
        {4'd6,  2'd1, 2'd0, 4'h0, 4'h0, 32'h0,         32'hFFFF_FFFF},   // R6
        {4'd4,  2'd1, 2'd0, 4'hC, 4'h0, 32'h0,         32'h0000_0000}    // R4
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic aw_phase(input logic [3:0] a);
        awaddr = a; awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        awvalid = 1'b0;
    endtask

    task automatic w_phase(input logic [31:0] d, input logic [3:0] s);
        wdata = d; wstrb = s; wvalid = 1'b1;
        while (!wready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        wvalid = 1'b0;
    endtask

    // Full write; hold > 0 keeps BREADY low that many cycles and checks R8.
    task automatic do_write(input int req, input logic [1:0] order, input logic [3:0] a,
                            input logic [31:0] d, input logic [3:0] s, input int hold);
        @(negedge clk);
        if (order == 2'd0) begin
            awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
            while (!(awready && wready)) @(negedge clk);
            @(posedge clk); @(negedge clk);
            awvalid = 1'b0; wvalid = 1'b0;
        end else if (order == 2'd1) begin
            aw_phase(a);
            repeat (2) @(negedge clk);
            check(7, {30'd0, bvalid, awready}, 32'd0);   // R7: held, not committed
            w_phase(d, s);
        end else begin
            w_phase(d, s);
            repeat (2) @(negedge clk);
            check(7, {30'd0, bvalid, wready}, 32'd0);    // R7: held, not committed
            aw_phase(a);
        end
        while (!bvalid) @(negedge clk);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(8, {29'd0, bvalid, awready, wready}, 32'd4);  // R8 held, writes blocked
        end
        check(req, {30'd0, bresp}, 32'd0);   // OKAY response
        bready = 1'b1;
        @(posedge clk); @(negedge clk);
        bready = 1'b0;
    endtask

    // Full read; hold > 0 keeps RREADY low and checks R9.
    task automatic do_read(input int req, input logic [3:0] a, input int hold,
                           output logic [31:0] d);
        logic [31:0] first;
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        first = rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(9, {30'd0, rvalid, arready}, 32'd2);   // R9 held, reads blocked
            check(9, rdata, first);                       // R9 data stable
        end
        check(req, {30'd0, rresp}, 32'd0);
        d = rdata;
        rready = 1'b1;
        @(posedge clk); @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        apply_reset();
        // R1: reset state of the handshake outputs and operands.
        check(1, {27'd0, awready, wready, arready, bvalid, rvalid}, 32'b11100);
        do_read(1, 4'h0, 0, rd); check(1, rd, 32'h0);
        do_read(1, 4'h4, 0, rd); check(1, rd, 32'h0);
        do_read(1, 4'hC, 0, rd); check(1, rd, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][75:74] == 2'd0)
                do_write(int'(VEC[v][79:76]), VEC[v][73:72], VEC[v][71:68],
                         VEC[v][63:32], VEC[v][67:64], 0);
            else begin
                do_read(int'(VEC[v][79:76]), VEC[v][71:68], 0, rd);
                check(int'(VEC[v][79:76]), rd, VEC[v][31:0]);
            end
        end

        // R8: response held while BREADY is low.
        do_write(8, 2'd0, 4'h0, 32'h0000_0011, 4'hF, 5);
        // R9: read data held while RREADY is low.
        do_read(9, 4'hC, 5, rd); check(9, rd, 32'h0000_0012);

        // R10: read accepted on the commit edge returns the old value.
        @(negedge clk);
        awaddr = 4'h0; wdata = 32'h0000_0022; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
        @(posedge clk); @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        araddr = 4'h0; arvalid = 1'b1;
        @(posedge clk); @(negedge clk);
        arvalid = 1'b0;
        check(10, {30'd0, rvalid, bvalid}, 32'd3);
        check(10, rdata, 32'h0000_0011);
        bready = 1'b1; rready = 1'b1;
        @(posedge clk); @(negedge clk);
        bready = 1'b0; rready = 1'b0;
        do_read(10, 4'h0, 0, rd); check(10, rd, 32'h0000_0022);

        // R1: reset in mid-run clears both operands.
        do_write(1, 2'd0, 4'h4, 32'h0000_0099, 4'hF, 0);
        apply_reset();
        do_read(1, 4'h0, 0, rd); check(1, rd, 32'h0);
        do_read(1, 4'h4, 0, rd); check(1, rd, 32'h0);
        finish_run();
    end
endmodule